// File: doc/BRIEF.md
# Polarity-Configurable Level Interrupt Aggregator

This block gathers 32 level-sensitive interrupt lines into a single request toward a parent interrupt controller. Each line first passes through a two-flop synchroniser. A per-source polarity bit then decides whether a high or a low level counts as asserted. Every cycle in which a source is asserted sets its pending bit. A pending bit stays set until software writes a one to it, so a short pulse is not lost.

An enable mask selects which pending sources drive the cascade request. A second, independent mask drives a separate summary output. Software can also read the synchronised pin levels directly.

Software reaches the block through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the registered state. A handler clears the pending bits it has serviced and reads the status register again, repeating until it reads zero. A source whose level is still active pends again at once, and no separate acknowledge path is needed.

Top module: `lic_cascade_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero and both `cascade_irq` and `summary_irq` are low.
- R2: Source n (`irq_in[n]`) occupies register bit 31−n in the status, enable, polarity, summary-enable and raw-level registers, so source 0 is bit 31.
- R3: A change on `irq_in` appears in the raw-level register (offset 0x5C) after two rising clock edges. The matching status bit sets on the third edge.
- R4: A polarity bit (offset 0x58) of 0 makes a high synchronised level asserted. A polarity bit of 1 makes a low level asserted.
- R5: Writing the status register (offset 0x50) clears each pending bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears every source that is not asserted.
- R6: When a clear and an asserted level fall on the same bit in the same cycle, the bit stays set.
- R7: `cascade_irq` is high exactly when some status bit is set and its enable bit (offset 0x54) is also set.
- R8: `summary_irq` is high exactly when some status bit is set and its summary-enable bit (offset 0x04) is also set. The enable register has no effect on it.
- R9: The enable, summary-enable and polarity registers take the whole written word and read it back unchanged.
- R10: Writes to the raw-level register or to any unmapped offset change no register, and unmapped offsets read zero.
- R11: A pending bit stays set after its source deasserts, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | 32 | Level interrupt inputs, bit n is source n |
| cascade_irq | output | 1 | Request to the parent controller (pending AND enable) |
| summary_irq | output | 1 | Summary request (pending AND summary-enable) |

## Verification
The synchroniser-latency assertion assumes `irq_in` is valid on the edges it checks. It is armed only after two edges out of reset, so the levels present during reset are never compared. The register-port assertions assume `reg_addr` and `reg_wdata` are stable around the edge on which `reg_wr` is high. The stimulus meets both conditions by changing every input on the falling clock edge only.

The random phase mixes sparse toggles on the inputs with writes to every offset, unmapped ones included. This makes clears meet still-asserted sources many times in the same cycle.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int LIC_NSRC = 32;
  localparam int LIC_DW   = 32;
  localparam int LIC_AW   = 8;

  localparam logic [LIC_AW-1:0] OFF_SUMEN = 8'h04;
  localparam logic [LIC_AW-1:0] OFF_STAT  = 8'h50;
  localparam logic [LIC_AW-1:0] OFF_ENA   = 8'h54;
  localparam logic [LIC_AW-1:0] OFF_POL   = 8'h58;
  localparam logic [LIC_AW-1:0] OFF_RAW   = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_SUMEN = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_ENA   = 3'd3,
    SEL_POL   = 3'd4,
    SEL_RAW   = 3'd5
  } lic_sel_e;

  // Offset decode; anything not listed selects nothing.
  function automatic lic_sel_e lic_decode(input logic [LIC_AW-1:0] a);
    lic_sel_e s;
    case (a)
      OFF_SUMEN: s = SEL_SUMEN;
      OFF_STAT:  s = SEL_STAT;
      OFF_ENA:   s = SEL_ENA;
      OFF_POL:   s = SEL_POL;
      OFF_RAW:   s = SEL_RAW;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Source n lands at register bit (N-1-n): R2 ordering.
  function automatic logic [LIC_NSRC-1:0] lic_src_to_reg(input logic [LIC_NSRC-1:0] v);
    logic [LIC_NSRC-1:0] r;
    for (int i = 0; i < LIC_NSRC; i++) r[LIC_NSRC-1-i] = v[i];
    return r;
  endfunction

  // Next pending word: clear by mask, then set wins (R5, R6).
  function automatic logic [LIC_NSRC-1:0] lic_pend_next(input logic [LIC_NSRC-1:0] cur,
                                                         input logic [LIC_NSRC-1:0] clr,
                                                         input logic [LIC_NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W      = lic_pkg::LIC_NSRC,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] sr_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) sr_q[s] <= '0;
    end else begin
      sr_q[0] <= din;
      for (int s = 1; s < STAGES; s++) sr_q[s] <= sr_q[s-1];
    end
  end

  assign dout = sr_q[STAGES-1];

  // Edges seen since reset release, saturating; arms the latency check.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      // R3: output equals the input sampled two edges earlier
      a_r3_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter int NSRC = LIC_NSRC,
  parameter int AW   = LIC_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output lic_sel_e        rd_sel,
  output logic [NSRC-1:0] ena_q,
  output logic [NSRC-1:0] sumen_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] clr_mask
);

  localparam int NWR = 3;  // enable, summary enable, polarity

  logic [NWR-1:0]           wr_hit;
  logic [NWR-1:0][NSRC-1:0] cfg_q;
  lic_sel_e                 sel;

  assign sel    = lic_decode(reg_addr);
  assign rd_sel = sel;

  assign wr_hit[0] = reg_wr && (sel == SEL_ENA);
  assign wr_hit[1] = reg_wr && (sel == SEL_SUMEN);
  assign wr_hit[2] = reg_wr && (sel == SEL_POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int g = 0; g < NWR; g++)
        if (wr_hit[g]) cfg_q[g] <= reg_wdata;
    end
  end

  assign ena_q   = cfg_q[0];
  assign sumen_q = cfg_q[1];
  assign pol_q   = cfg_q[2];

  // Write-one-to-clear strobe toward the pending register
  assign clr_mask = (reg_wr && (sel == SEL_STAT)) ? reg_wdata : '0;

  // R10: writes outside the writable set leave configuration untouched
  a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (sel == SEL_NONE || sel == SEL_RAW)) |=>
      ($stable(ena_q) && $stable(sumen_q) && $stable(pol_q)));

  // R9: a configuration write is captured whole
  a_r9_ena_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_ENA) |=> (ena_q == $past(reg_wdata)));

endmodule

// File: rtl/lic_pending.sv
module lic_pending
  import lic_pkg::*;
#(
  parameter int NSRC = LIC_NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] status_q
);

  logic [NSRC-1:0] status_d;

  assign status_d = lic_pend_next(status_q, clr_mask, set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R6: an asserted level is pending on the next cycle whatever the clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R5: cleared bits with no set fall
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));

  // R11: uncleared pending bits persist
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |=>
      ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

endmodule

// File: rtl/lic_cascade_ctrl.sv
module lic_cascade_ctrl
  import lic_pkg::*;
#(
  parameter int NSRC   = LIC_NSRC,  // must equal DW
  parameter int DW     = LIC_DW,
  parameter int AW     = LIC_AW,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic          cascade_irq,
  output logic          summary_irq
);

  // Named internal events
  logic [NSRC-1:0] lvl_src;   // synchronised, source order
  logic [NSRC-1:0] lvl_reg;   // synchronised, register order
  logic [NSRC-1:0] act_reg;   // polarity-corrected, register order
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] ena, sumen, pol, clr_mask;
  logic [NSRC-1:0] fire_vec, sum_vec;
  lic_sel_e        rd_sel;

  lic_sync #(.W(NSRC), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_in),
    .dout (lvl_src)
  );

  // R2: MSB-first numbering
  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_map
      assign lvl_reg[NSRC-1-n] = lvl_src[n];
    end
  endgenerate

  // R4: polarity bit inverts the sense of the level
  assign act_reg = lvl_reg ^ pol;

  lic_regfile #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .rd_sel   (rd_sel),
    .ena_q    (ena),
    .sumen_q  (sumen),
    .pol_q    (pol),
    .clr_mask (clr_mask)
  );

  lic_pending #(.NSRC(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (act_reg),
    .clr_mask(clr_mask),
    .status_q(status)
  );

  assign fire_vec    = status & ena;
  assign sum_vec     = status & sumen;
  assign cascade_irq = |fire_vec;
  assign summary_irq = |sum_vec;

  always_comb begin
    case (rd_sel)
      SEL_SUMEN: reg_rdata = sumen;
      SEL_STAT:  reg_rdata = status;
      SEL_ENA:   reg_rdata = ena;
      SEL_POL:   reg_rdata = pol;
      SEL_RAW:   reg_rdata = lvl_reg;
      default:   reg_rdata = '0;
    endcase
  end

  // R1: quiet state while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (status == '0 && ena == '0 && pol == '0 && sumen == '0
                                && !cascade_irq && !summary_irq);
    end
  end

  // R7: no request without something pending
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !cascade_irq);

  // R8: summary output silent when its mask is clear, whatever the enable
  a_r8_summary_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (sumen == '0) |-> !summary_irq);

endmodule

// File: tb/tb_lic_cascade_ctrl.sv
module tb_lic_cascade_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SAMP       = CLK_PERIOD * 3 / 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] irq_in;
  logic        cascade_irq;
  logic        summary_irq;

  int n_checks = 0;
  int n_fail   = 0;

  lic_cascade_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_in     (irq_in),
    .cascade_irq(cascade_irq),
    .summary_irq(summary_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_p1, m_p2;                 // pipeline, indexed by source
  logic [31:0] m_stat, m_en, m_sum, m_pol; // indexed by register bit
  logic [31:0] m_next;
  logic        m_act, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_stat = 0; m_en = 0; m_sum = 0; m_pol = 0;
    end else begin
      for (int n = 0; n < 32; n++) begin
        m_act = m_p2[n] ^ m_pol[31-n];
        m_clr = reg_wr && (reg_addr == 8'h50) && reg_wdata[31-n];
        m_next[31-n] = m_act || (m_stat[31-n] && !m_clr);
      end
      if (reg_wr) begin
        if (reg_addr == 8'h04) m_sum = reg_wdata;
        if (reg_addr == 8'h54) m_en  = reg_wdata;
        if (reg_addr == 8'h58) m_pol = reg_wdata;
      end
      m_stat = m_next;
      m_p2   = m_p1;
      m_p1   = irq_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 8'h04) r = m_sum;
    else if (a == 8'h50) r = m_stat;
    else if (a == 8'h54) r = m_en;
    else if (a == 8'h58) r = m_pol;
    else if (a == 8'h5C) for (int n = 0; n < 32; n++) r[31-n] = m_p2[n];
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a == 8'h50) return "R5 status read";
    if (a == 8'h58) return "R4 polarity read";
    if (a == 8'h5C) return "R3 raw read";
    if (a == 8'h04 || a == 8'h54) return "R9 mask read";
    return "R10 unmapped read";
  endfunction

  // Per-cycle comparison, sampled away from the edges
  always begin
    @(posedge clk);
    #(SAMP);
    if (rst_n === 1'b1) begin
      check("R7 cascade", {31'b0, cascade_irq}, {31'b0, |(m_stat & m_en)});
      check("R8 summary", {31'b0, summary_irq}, {31'b0, |(m_stat & m_sum)});
      check(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic probe(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #(SAMP);
    check(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 0; irq_in = 0;

    // R1: reset state
    probe(8'h04, 0, "R1 summary-enable at reset");
    probe(8'h50, 0, "R1 status at reset");
    probe(8'h54, 0, "R1 enable at reset");
    probe(8'h58, 0, "R1 polarity at reset");
    probe(8'h5C, 0, "R1 raw at reset");
    check("R1 cascade at reset", {31'b0, cascade_irq}, 0);
    check("R1 summary at reset", {31'b0, summary_irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: enable sources 0 and 31
    wr(8'h54, 32'h8000_0001);
    probe(8'h54, 32'h8000_0001, "R9 enable readback");

    // R3 / R2: latency and bit placement for source 0
    @(negedge clk);
    reg_addr = 8'h5C; irq_in[0] = 1'b1;
    @(posedge clk); #(SAMP);
    check("R3 raw after one edge", reg_rdata, 32'h0);
    @(posedge clk); #(SAMP);
    check("R3 raw after two edges (R2 bit 31)", reg_rdata, 32'h8000_0000);
    @(negedge clk);
    reg_addr = 8'h50;
    @(posedge clk); #(SAMP);
    check("R3 status on third edge", reg_rdata, 32'h8000_0000);
    check("R7 cascade with enabled source", {31'b0, cascade_irq}, 1);

    // R6: clear-all while still asserted
    wr(8'h50, 32'hFFFF_FFFF);
    probe(8'h50, 32'h8000_0000, "R6 set wins over clear");

    // R11 / R5
    @(negedge clk); irq_in[0] = 1'b0;
    idle(4);
    probe(8'h50, 32'h8000_0000, "R11 pending held after deassert");
    wr(8'h50, 32'h0000_0001);
    probe(8'h50, 32'h8000_0000, "R5 zero bits unchanged");
    wr(8'h50, 32'h8000_0000);
    probe(8'h50, 32'h0, "R5 one bit clears");
    check("R7 cascade low after clear", {31'b0, cascade_irq}, 0);

    // R4: active-low source 29 (bit 2), input low
    wr(8'h58, 32'h0000_0004);
    idle(3);
    probe(8'h50, 32'h0000_0004, "R4 low level asserted with polarity 1");
    check("R7 not enabled so cascade low", {31'b0, cascade_irq}, 0);
    wr(8'h04, 32'h0000_0004);
    @(posedge clk); #(SAMP);
    check("R8 summary follows its own mask", {31'b0, summary_irq}, 1);
    check("R8 enable does not gate summary", {31'b0, cascade_irq}, 0);
    @(negedge clk); irq_in[29] = 1'b1;
    idle(4);
    wr(8'h50, 32'h0000_0004);
    probe(8'h50, 32'h0, "R4 high level not asserted with polarity 1");
    check("R8 summary low after clear", {31'b0, summary_irq}, 0);
    probe(8'h5C, 32'h0000_0004, "R2 source 29 at raw bit 2");

    // R10: writes ignored
    wr(8'h5C, 32'hFFFF_FFFF);
    probe(8'h5C, 32'h0000_0004, "R10 raw write ignored");
    wr(8'h20, 32'hFFFF_FFFF);
    probe(8'h20, 32'h0, "R10 unmapped reads zero");
    probe(8'h54, 32'h8000_0001, "R10 enable untouched");
    probe(8'h58, 32'h0000_0004, "R9 polarity readback");

    // Random phase, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      irq_in    = irq_in ^ ($urandom & $urandom & $urandom);
      reg_wr    = (($urandom % 4) == 0);
      reg_wdata = $urandom;
      case ($urandom % 7)
        0: reg_addr = 8'h04;
        1: reg_addr = 8'h50;
        2: reg_addr = 8'h54;
        3: reg_addr = 8'h58;
        4: reg_addr = 8'h5C;
        5: reg_addr = 8'h20;
        default: reg_addr = 8'h50;
      endcase
    end
    @(negedge clk); reg_wr = 1'b0;
    idle(3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule